// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block schedules a short, high-priority group of one to four converter channels. A configuration side programs the group length, the scan mode, the trigger source and, per rank, a channel number, a sampling-time code and a 12-bit offset. Once the converter is enabled, the group runs on one of three start sources: a software start, a qualifying edge on an external trigger line, or automatic chaining when a regular-group conversion completes.

The converter core is abstracted to a cycle counter plus a sample input. For each rank the block drives the channel number, waits the full conversion time for that rank's sampling code, and then captures the sample. It subtracts the rank's offset and stores the signed result in that rank's result register. An end-of-group flag rises only after the last rank of the sequence. Reading any result clears it. In discontinuous mode each start converts a single rank. A stop request aborts the group, but only when the system conditions allow it.

Top module: `inj_group_seq`

## Requirements
- R1: After reset the sequencer is idle: `conv_busy`, `grp_done`, `sw_pend` and `cfg_err` are 0, `conv_chan` is 0, every result reads 0, scan mode is off and the length field is 0.
- R2: The length field holds the number of conversions minus one. A group converts ranks 0 up to the length in rank order. Each rank's result is its sample minus its offset, stored as a two's-complement 16-bit value and read back on `rd_data` when `rd_rank` selects it.
- R3: With scan mode off the stored length is forced to 0, whatever is written. A rank write whose index is not 0 is rejected and raises `cfg_err` for one cycle.
- R4: A rank write with index i goes to sequence slot (i + 3 - length) mod 4, and the ranks run from slot 3 - length upward. A write with an index above the current length clears the slot it maps to, setting its channel and sampling code to 0. Its offset is still stored.
- R5: Sampling codes 0 to 7 give conversion times of 16, 21, 28, 36, 60, 108, 204 and 396 clock cycles: the sampling time plus 12. Each rank occupies exactly its conversion time.
- R6: `grp_done` is set on the cycle the last rank is captured, never earlier. A cycle with `rd_en` high clears it.
- R7: `sw_start` sets `sw_pend`, and the group begins on the next cycle, which clears `sw_pend`. A software start is ignored while the group is busy, while `adc_en` is low, while an external edge is selected, or while auto-chaining is on.
- R8: Edge selection code 0 = none (acts as software start), 1 = rising, 2 = falling, 3 = both. With an edge selected, the group begins on the clock edge that sees the qualifying transition of `ext_trig`. Other transitions are ignored.
- R9: With auto-chaining on, a `reg_done` pulse starts the group on that edge. A configuration write that asks for auto-chaining together with a non-zero edge selection is rejected with `cfg_err`.
- R10: A configuration write that enables discontinuous mode and auto-chaining together is rejected with `cfg_err`. So is a write that changes either setting while `adc_en` is high. A rejected write changes nothing.
- R11: In discontinuous mode each start converts only the next rank. `grp_done` rises only after the start that converts the last rank.
- R12: `stop_req` is accepted only when `reg_pending` is low and auto-chaining is off. The sequencer then returns to idle with no result and no `grp_done`. Otherwise `cfg_err` pulses and the group keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_en | input | 1 | Converter enabled |
| cfg_wr | input | 1 | Group configuration write strobe |
| cfg_scan | input | 1 | Scan mode enable |
| cfg_len | input | LEN_W (2) | Number of conversions minus one |
| cfg_edge | input | 2 | Trigger edge select (0 none, 1 rise, 2 fall, 3 both) |
| cfg_auto | input | 1 | Auto-chaining after regular conversion |
| cfg_disc | input | 1 | Discontinuous mode |
| rank_wr | input | 1 | Rank programming strobe |
| rank_idx | input | LEN_W (2) | Rank index (0 = first rank) |
| rank_chan | input | CHAN_W (5) | Channel number for the rank |
| rank_smp | input | 3 | Sampling-time code for the rank |
| rank_ofs | input | DATA_W (12) | Offset for the rank |
| sw_start | input | 1 | Software start request |
| ext_trig | input | 1 | External trigger line |
| reg_done | input | 1 | Regular-group conversion finished (pulse) |
| reg_pending | input | 1 | A regular conversion is pending |
| stop_req | input | 1 | Stop request |
| smp_data | input | DATA_W (12) | Sample from the converter core |
| rd_en | input | 1 | Result read strobe |
| rd_rank | input | LEN_W (2) | Rank of the result to read |
| conv_chan | output | CHAN_W (5) | Channel being converted (0 when idle) |
| conv_busy | output | 1 | A conversion is in progress |
| sw_pend | output | 1 | Software start bit, self-clearing |
| grp_done | output | 1 | End-of-group flag |
| cfg_err | output | 1 | Configuration or stop error pulse |
| rd_data | output | RES_W (16) | Signed result of the selected rank |

## Verification
Several properties are checked on every cycle. Scan-off forces a zero length. Auto-chaining never coexists with an external edge, and discontinuous mode never coexists with auto-chaining. A rejected write leaves both settings unchanged. The conversion counter stays within the longest conversion time. The end-of-group flag rises only after the last rank, a pending software start launches the group on the next cycle, and an accepted stop always lands in idle. Only the bench scenarios can show exact conversion durations per sampling code, slot placement for different lengths, offset arithmetic, trigger-edge qualification and the single-rank progress of discontinuous mode, because these depend on sequences of writes and starts.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

   localparam int SMP_CODE_W = 3;
   localparam int CONV_BASE  = 12;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } seq_st_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } trig_edge_e;

   // sampling clocks per code; the first code is rounded to whole clocks
   function automatic int unsigned smp_clocks(input logic [SMP_CODE_W-1:0] code);
      case (code)
         3'd0:    return 4;
         3'd1:    return 9;
         3'd2:    return 16;
         3'd3:    return 24;
         3'd4:    return 48;
         3'd5:    return 96;
         3'd6:    return 192;
         default: return 384;
      endcase
   endfunction

   function automatic int unsigned conv_total(input logic [SMP_CODE_W-1:0] code);
      return smp_clocks(code) + CONV_BASE;
   endfunction

endpackage

// File: rtl/inj_seq_cfg.sv
module inj_seq_cfg
   import inj_seq_pkg::*;
#(
   parameter int N_RANK = 4,
   parameter int LEN_W  = 2,
   parameter int CHAN_W = 5,
   parameter int DATA_W = 12
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  adc_en,
   input  logic                                  cfg_wr,
   input  logic                                  cfg_scan,
   input  logic [LEN_W-1:0]                      cfg_len,
   input  logic [1:0]                            cfg_edge,
   input  logic                                  cfg_auto,
   input  logic                                  cfg_disc,
   input  logic                                  rank_wr,
   input  logic [LEN_W-1:0]                      rank_idx,
   input  logic [CHAN_W-1:0]                     rank_chan,
   input  logic [SMP_CODE_W-1:0]                 rank_smp,
   input  logic [DATA_W-1:0]                     rank_ofs,
   input  logic                                  stop_bad,
   output logic [LEN_W-1:0]                      len_q,
   output logic [1:0]                            edge_q,
   output logic                                  auto_q,
   output logic                                  disc_q,
   output logic [N_RANK-1:0][CHAN_W-1:0]         slot_chan,
   output logic [N_RANK-1:0][SMP_CODE_W-1:0]     slot_code,
   output logic [N_RANK-1:0][DATA_W-1:0]         ofs_q,
   output logic                                  cfg_err
);

   logic             scan_q;
   logic             bad_cfg;
   logic             bad_rank;
   logic             rank_ok;
   logic             in_range;
   logic [LEN_W-1:0] wr_slot;

   // rejection rules for group settings and rank writes
   assign bad_cfg  = cfg_wr & ((cfg_auto & (trig_edge_e'(cfg_edge) != EDGE_NONE)) |
                               (cfg_auto & cfg_disc) |
                               (adc_en & ((cfg_auto != auto_q) | (cfg_disc != disc_q))));
   assign bad_rank = rank_wr & ~scan_q & (rank_idx != '0);
   assign rank_ok  = rank_wr & ~bad_rank;
   assign in_range = (rank_idx <= len_q);
   // slot placement wraps, so indices past the length land on unused slots
   assign wr_slot  = rank_idx + (LEN_W'(N_RANK - 1) - len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q  <= 1'b0;
         len_q   <= '0;
         edge_q  <= '0;
         auto_q  <= 1'b0;
         disc_q  <= 1'b0;
         cfg_err <= 1'b0;
      end else begin
         cfg_err <= bad_cfg | bad_rank | stop_bad;
         if (cfg_wr && !bad_cfg) begin
            scan_q <= cfg_scan;
            len_q  <= cfg_scan ? cfg_len : '0;
            edge_q <= cfg_edge;
            auto_q <= cfg_auto;
            disc_q <= cfg_disc;
         end
      end
   end

   for (genvar s = 0; s < N_RANK; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_chan[s] <= '0;
            slot_code[s] <= '0;
         end else if (rank_ok && (wr_slot == LEN_W'(s))) begin
            slot_chan[s] <= in_range ? rank_chan : '0;
            slot_code[s] <= in_range ? rank_smp  : '0;
         end
      end
   end

   for (genvar r = 0; r < N_RANK; r++) begin : g_ofs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   ofs_q[r] <= '0;
         else if (rank_ok && (rank_idx == LEN_W'(r))) ofs_q[r] <= rank_ofs;
      end
   end

   p_scan_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_q |-> (len_q == '0));

   p_auto_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      auto_q |-> (edge_q == 2'd0));

   p_disc_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(auto_q && disc_q));

   p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !$past(cfg_wr && !bad_cfg)) |-> ($stable(auto_q) && $stable(disc_q)));

endmodule

// File: rtl/inj_seq_trig.sv
module inj_seq_trig
   import inj_seq_pkg::*;
#(
   parameter int TRIG_SYNC = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_trig,
   input  logic [1:0] edge_sel,
   input  logic       reg_done,
   input  logic       auto_en,
   output logic       ext_hit,
   output logic       auto_hit
);

   logic trig_s;
   logic trig_d;
   logic rise;
   logic fall;

   if (TRIG_SYNC > 0) begin : g_sync
      logic [TRIG_SYNC-1:0] sy;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sy <= '0;
         end else begin
            sy[0] <= ext_trig;
            for (int k = 1; k < TRIG_SYNC; k++) sy[k] <= sy[k-1];
         end
      end
      assign trig_s = sy[TRIG_SYNC-1];
   end else begin : g_direct
      assign trig_s = ext_trig;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_d <= 1'b0;
      else        trig_d <= trig_s;
   end

   assign rise = trig_s & ~trig_d;
   assign fall = ~trig_s & trig_d;

   always_comb begin
      case (trig_edge_e'(edge_sel))
         EDGE_RISE: ext_hit = rise;
         EDGE_FALL: ext_hit = fall;
         EDGE_BOTH: ext_hit = rise | fall;
         default:   ext_hit = 1'b0;
      endcase
   end

   assign auto_hit = auto_en & reg_done;

endmodule

// File: rtl/inj_conv_timer.sv
module inj_conv_timer
   import inj_seq_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [SMP_CODE_W-1:0] code,
   input  logic                  run,
   output logic                  expire
);

   localparam int unsigned MAX_TOTAL = conv_total(3'd7);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (load)                  cnt <= CNT_W'(conv_total(code) - 1);
      else if (run && (cnt != '0))    cnt <= cnt - 1'b1;
   end

   assign expire = run & (cnt == '0);

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (32'(cnt) < MAX_TOTAL));

endmodule

// File: rtl/inj_group_seq.sv
module inj_group_seq
   import inj_seq_pkg::*;
#(
   parameter int N_RANK    = 4,
   parameter int CHAN_W    = 5,
   parameter int DATA_W    = 12,
   parameter int RES_W     = 16,
   parameter int TRIG_SYNC = 0,
   localparam int LEN_W    = $clog2(N_RANK)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adc_en,
   input  logic                  cfg_wr,
   input  logic                  cfg_scan,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic [1:0]            cfg_edge,
   input  logic                  cfg_auto,
   input  logic                  cfg_disc,
   input  logic                  rank_wr,
   input  logic [LEN_W-1:0]      rank_idx,
   input  logic [CHAN_W-1:0]     rank_chan,
   input  logic [SMP_CODE_W-1:0] rank_smp,
   input  logic [DATA_W-1:0]     rank_ofs,
   input  logic                  sw_start,
   input  logic                  ext_trig,
   input  logic                  reg_done,
   input  logic                  reg_pending,
   input  logic                  stop_req,
   input  logic [DATA_W-1:0]     smp_data,
   input  logic                  rd_en,
   input  logic [LEN_W-1:0]      rd_rank,
   output logic [CHAN_W-1:0]     conv_chan,
   output logic                  conv_busy,
   output logic                  sw_pend,
   output logic                  grp_done,
   output logic                  cfg_err,
   output logic [RES_W-1:0]      rd_data
);

   localparam int CNT_W = $clog2(conv_total(3'd7));

   if ((N_RANK < 2) || ((N_RANK & (N_RANK - 1)) != 0)) begin : g_chk_rank
      $error("N_RANK must be a power of two of at least 2");
   end
   if (RES_W <= DATA_W) begin : g_chk_res
      $error("RES_W must exceed DATA_W");
   end

   logic [LEN_W-1:0]                  len_q;
   logic [1:0]                        edge_q;
   logic                              auto_q;
   logic                              disc_q;
   logic [N_RANK-1:0][CHAN_W-1:0]     slot_chan;
   logic [N_RANK-1:0][SMP_CODE_W-1:0] slot_code;
   logic [N_RANK-1:0][DATA_W-1:0]     ofs_q;
   logic [N_RANK-1:0][RES_W-1:0]      res_q;

   seq_st_e          state;
   logic [LEN_W-1:0] step;
   logic [LEN_W-1:0] cur_slot;
   logic [LEN_W-1:0] load_slot;
   logic             ext_hit;
   logic             auto_hit;
   logic             expire;
   logic             run;
   logic             begin_now;
   logic             stop_ok;
   logic             stop_bad;
   logic             sw_ok;
   logic             last_rank;
   logic             load;
   logic [RES_W-1:0] diff;

   inj_seq_cfg #(
      .N_RANK (N_RANK),
      .LEN_W  (LEN_W),
      .CHAN_W (CHAN_W),
      .DATA_W (DATA_W)
   ) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .adc_en    (adc_en),
      .cfg_wr    (cfg_wr),
      .cfg_scan  (cfg_scan),
      .cfg_len   (cfg_len),
      .cfg_edge  (cfg_edge),
      .cfg_auto  (cfg_auto),
      .cfg_disc  (cfg_disc),
      .rank_wr   (rank_wr),
      .rank_idx  (rank_idx),
      .rank_chan (rank_chan),
      .rank_smp  (rank_smp),
      .rank_ofs  (rank_ofs),
      .stop_bad  (stop_bad),
      .len_q     (len_q),
      .edge_q    (edge_q),
      .auto_q    (auto_q),
      .disc_q    (disc_q),
      .slot_chan (slot_chan),
      .slot_code (slot_code),
      .ofs_q     (ofs_q),
      .cfg_err   (cfg_err)
   );

   inj_seq_trig #(
      .TRIG_SYNC (TRIG_SYNC)
   ) trig_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_trig (ext_trig),
      .edge_sel (edge_q),
      .reg_done (reg_done),
      .auto_en  (auto_q),
      .ext_hit  (ext_hit),
      .auto_hit (auto_hit)
   );

   inj_conv_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .code   (slot_code[load_slot]),
      .run    (run),
      .expire (expire)
   );

   // sequencing control
   assign run       = (state == ST_CONV);
   assign cur_slot  = step + (LEN_W'(N_RANK - 1) - len_q);
   assign load_slot = run ? (cur_slot + 1'b1) : cur_slot;
   assign last_rank = (step == len_q);
   assign stop_ok   = stop_req & ~reg_pending & ~auto_q;
   assign stop_bad  = stop_req & ~stop_ok;
   assign begin_now = ~run & adc_en & (sw_pend | ext_hit | auto_hit);
   assign sw_ok     = sw_start & adc_en & ~sw_pend & ~auto_q &
                      (trig_edge_e'(edge_q) == EDGE_NONE);
   assign load      = ~stop_ok & ((~run & begin_now) |
                                  (run & expire & ~last_rank & ~disc_q));

   assign diff = {{(RES_W - DATA_W){1'b0}}, smp_data} -
                 {{(RES_W - DATA_W){1'b0}}, ofs_q[step]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         step    <= '0;
         sw_pend <= 1'b0;
      end else if (stop_ok) begin
         state   <= ST_IDLE;
         step    <= '0;
         sw_pend <= 1'b0;
      end else if (!run) begin
         if (begin_now) begin
            state   <= ST_CONV;
            sw_pend <= 1'b0;
         end else if (sw_ok) begin
            sw_pend <= 1'b1;
         end
      end else if (expire) begin
         if (last_rank) begin
            state <= ST_IDLE;
            step  <= '0;
         end else begin
            step <= step + 1'b1;
            if (disc_q) state <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    grp_done <= 1'b0;
      else if (!stop_ok && run && expire && last_rank) grp_done <= 1'b1;
      else if (rd_en)                                grp_done <= 1'b0;
   end

   for (genvar r = 0; r < N_RANK; r++) begin : g_res
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            res_q[r] <= '0;
         else if (!stop_ok && run && expire && (step == LEN_W'(r)))
            res_q[r] <= diff;
      end
   end

   assign conv_chan = run ? slot_chan[cur_slot] : '0;
   assign conv_busy = run;
   assign rd_data   = res_q[rd_rank];

   p_eog_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_done) |-> $past((state == ST_CONV) && (step == len_q)));

   p_swpend_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pend && (state == ST_IDLE) && adc_en && !stop_req) |=> (state == ST_CONV) && !sw_pend);

   p_busy_no_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV) |-> !sw_pend);

   p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !reg_pending && !auto_q) |=> (state == ST_IDLE) && (step == '0));

endmodule

// File: tb/inj_group_seq_tb_top.sv
`timescale 1ns/1ps
module inj_group_seq_tb_top;

   typedef struct packed {
      logic [1:0]        len;
      logic [3:0][2:0]   code;
      logic [3:0][4:0]   chan;
      logic [3:0][11:0]  ofs;
   } vec_t;

   localparam vec_t VT [5] = '{
      '{len:2'd0, code:{3'd0,3'd0,3'd0,3'd0}, chan:{5'd0,5'd0,5'd0,5'd3},
        ofs:{12'd0,12'd0,12'd0,12'd0}},
      '{len:2'd1, code:{3'd0,3'd0,3'd2,3'd1}, chan:{5'd0,5'd0,5'd9,5'd5},
        ofs:{12'd0,12'd0,12'h100,12'd10}},
      '{len:2'd2, code:{3'd0,3'd0,3'd4,3'd3}, chan:{5'd0,5'd7,5'd31,5'd1},
        ofs:{12'd0,12'd0,12'd5,12'hFFF}},
      '{len:2'd3, code:{3'd2,3'd1,3'd0,3'd5}, chan:{5'd8,5'd6,5'd4,5'd2},
        ofs:{12'h800,12'd2,12'd1,12'd0}},
      '{len:2'd3, code:{3'd0,3'd0,3'd6,3'd7}, chan:{5'd13,5'd12,5'd11,5'd10},
        ofs:{12'd0,12'd0,12'd0,12'd0}}
   };

   localparam int TOT [8] = '{16, 21, 28, 36, 60, 108, 204, 396};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adc_en = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_scan = 1'b0;
   logic [1:0]  cfg_len = '0;
   logic [1:0]  cfg_edge = '0;
   logic        cfg_auto = 1'b0;
   logic        cfg_disc = 1'b0;
   logic        rank_wr = 1'b0;
   logic [1:0]  rank_idx = '0;
   logic [4:0]  rank_chan = '0;
   logic [2:0]  rank_smp = '0;
   logic [11:0] rank_ofs = '0;
   logic        sw_start = 1'b0;
   logic        ext_trig = 1'b0;
   logic        reg_done = 1'b0;
   logic        reg_pending = 1'b0;
   logic        stop_req = 1'b0;
   logic [11:0] smp_data;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_rank = '0;
   logic [4:0]  conv_chan;
   logic        conv_busy;
   logic        sw_pend;
   logic        grp_done;
   logic        cfg_err;
   logic [15:0] rd_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // converter core model: the sample encodes the channel being converted
   assign smp_data = {conv_chan, 7'h2B};

   inj_group_seq dut_i (
      .clk(clk), .rst_n(rst_n), .adc_en(adc_en),
      .cfg_wr(cfg_wr), .cfg_scan(cfg_scan), .cfg_len(cfg_len), .cfg_edge(cfg_edge),
      .cfg_auto(cfg_auto), .cfg_disc(cfg_disc),
      .rank_wr(rank_wr), .rank_idx(rank_idx), .rank_chan(rank_chan),
      .rank_smp(rank_smp), .rank_ofs(rank_ofs),
      .sw_start(sw_start), .ext_trig(ext_trig), .reg_done(reg_done),
      .reg_pending(reg_pending), .stop_req(stop_req), .smp_data(smp_data),
      .rd_en(rd_en), .rd_rank(rd_rank),
      .conv_chan(conv_chan), .conv_busy(conv_busy), .sw_pend(sw_pend),
      .grp_done(grp_done), .cfg_err(cfg_err), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_res(input int ch, input int ofs);
      return ((ch << 7) | 'h2B) - ofs;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cfg_w(input bit scan, input int len, input int edg, input bit au, input bit di);
      cfg_scan = scan; cfg_len = 2'(len); cfg_edge = 2'(edg); cfg_auto = au; cfg_disc = di;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rank_w(input int idx, input int ch, input int code, input int ofs);
      rank_idx = 2'(idx); rank_chan = 5'(ch); rank_smp = 3'(code); rank_ofs = 12'(ofs);
      rank_wr = 1'b1;
      @(negedge clk);
      rank_wr = 1'b0;
   endtask

   // counts negedges from the one after a start was driven until grp_done
   task automatic wait_grp(input int lim, output int cyc);
      cyc = 0;
      while (!grp_done && cyc < lim) begin
         @(negedge clk);
         cyc++;
         sw_start = 1'b0;
         reg_done = 1'b0;
      end
   endtask

   task automatic rd_chk(input string tag, input int rank, input int exp);
      rd_rank = 2'(rank);
      #1;
      chk(tag, int'($signed(rd_data)), exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 busy", int'(conv_busy), 0);
      chk("R1 grp_done", int'(grp_done), 0);
      chk("R1 sw_pend", int'(sw_pend), 0);
      chk("R1 cfg_err", int'(cfg_err), 0);
      chk("R1 conv_chan", int'(conv_chan), 0);
      rd_rank = 2'd3; #1;
      chk("R1 result", int'(rd_data), 0);

      adc_en = 1'b1;

      // table-driven groups: R2 ordering and offsets, R5 timing, R6 flag
      for (int v = 0; v < 5; v++) begin
         int expc;
         cfg_w(1'b1, int'(VT[v].len), 0, 1'b0, 1'b0);
         expc = 2;
         for (int k = 0; k <= int'(VT[v].len); k++) begin
            rank_w(k, int'(VT[v].chan[k]), int'(VT[v].code[k]), int'(VT[v].ofs[k]));
            expc += TOT[VT[v].code[k]];
         end
         sw_start = 1'b1;
         wait_grp(3000, c);
         chk("R5 group duration", c, expc);
         for (int k = 0; k <= int'(VT[v].len); k++)
            rd_chk("R2 rank result", k, exp_res(int'(VT[v].chan[k]), int'(VT[v].ofs[k])));
         chk("R6 cleared by read", int'(grp_done), 0);
      end

      // R3: scan off
      cfg_w(1'b0, 3, 0, 1'b0, 1'b0);
      chk("R3 scan-off cfg accepted", int'(cfg_err), 0);
      rank_w(2, 17, 0, 0);
      chk("R3 rank 2 rejected", int'(cfg_err), 1);
      rank_w(0, 20, 0, 0);
      chk("R3 rank 0 accepted", int'(cfg_err), 0);
      sw_start = 1'b1;
      wait_grp(3000, c);
      chk("R3 single rank converted", c, 18);
      rd_chk("R3 result", 0, exp_res(20, 0));

      // R4: slot placement and clearing
      cfg_w(1'b1, 3, 0, 1'b0, 1'b0);
      rank_w(0, 1, 0, 0);
      rank_w(1, 2, 0, 0);
      rank_w(2, 3, 0, 0);
      rank_w(3, 4, 0, 0);
      cfg_w(1'b1, 1, 0, 1'b0, 1'b0);
      rank_w(2, 30, 1, 0);
      cfg_w(1'b1, 3, 0, 1'b0, 1'b0);
      sw_start = 1'b1;
      wait_grp(3000, c);
      chk("R4 duration after slot clear", c, 66);
      rd_chk("R4 cleared slot rank0", 0, exp_res(0, 0));
      rd_chk("R4 rank1 kept", 1, exp_res(2, 0));
      rd_chk("R4 rank2 kept", 2, exp_res(3, 0));
      rd_chk("R4 rank3 kept", 3, exp_res(4, 0));

      // R7: start ignored while busy
      cfg_w(1'b1, 0, 0, 1'b0, 1'b0);
      rank_w(0, 9, 7, 0);
      sw_start = 1'b1;
      c = 0;
      while (!grp_done && c < 3000) begin
         @(negedge clk);
         c++;
         sw_start = (c == 10);
         if (c == 11) chk("R7 busy start ignored", int'(sw_pend), 0);
      end
      chk("R7 no restart", c, 398);
      rd_chk("R7 result", 0, exp_res(9, 0));
      adc_en = 1'b0;
      sw_start = 1'b1; tick(); sw_start = 1'b0;
      chk("R7 disabled start ignored", int'(sw_pend), 0);
      adc_en = 1'b1;

      // R8: trigger edges
      cfg_w(1'b1, 0, 1, 1'b0, 1'b0);
      rank_w(0, 9, 0, 0);
      sw_start = 1'b1; tick(); sw_start = 1'b0; tick();
      chk("R7 sw start ignored with edge", int'(sw_pend) + int'(conv_busy), 0);
      ext_trig = 1'b1;
      wait_grp(3000, c);
      chk("R8 rising edge start", c, 17);
      rd_chk("R8 result", 0, exp_res(9, 0));
      ext_trig = 1'b0; repeat (3) tick();
      chk("R8 falling ignored in rise mode", int'(conv_busy), 0);
      cfg_w(1'b1, 0, 2, 1'b0, 1'b0);
      ext_trig = 1'b1; repeat (3) tick();
      chk("R8 rising ignored in fall mode", int'(conv_busy), 0);
      ext_trig = 1'b0;
      wait_grp(3000, c);
      chk("R8 falling edge start", c, 17);
      rd_chk("R8 result fall", 0, exp_res(9, 0));
      cfg_w(1'b1, 0, 3, 1'b0, 1'b0);
      ext_trig = 1'b1;
      wait_grp(3000, c);
      chk("R8 both-edge rise", c, 17);
      rd_chk("R8 result both", 0, exp_res(9, 0));
      ext_trig = 1'b0;
      wait_grp(3000, c);
      chk("R8 both-edge fall", c, 17);
      rd_chk("R8 result both fall", 0, exp_res(9, 0));
      cfg_w(1'b1, 0, 0, 1'b0, 1'b0);
      ext_trig = 1'b1; repeat (3) tick();
      chk("R8 none ignores line", int'(conv_busy) + int'(grp_done), 0);
      ext_trig = 1'b0; tick();

      // R10: legality of discontinuous mode
      cfg_w(1'b1, 2, 0, 1'b0, 1'b1);
      chk("R10 change while enabled", int'(cfg_err), 1);
      adc_en = 1'b0;
      cfg_w(1'b1, 2, 0, 1'b1, 1'b1);
      chk("R10 disc with auto", int'(cfg_err), 1);
      cfg_w(1'b1, 2, 0, 1'b0, 1'b1);
      chk("R10 disc alone accepted", int'(cfg_err), 0);
      adc_en = 1'b1;

      // R11: discontinuous progress
      rank_w(0, 1, 0, 0);
      rank_w(1, 2, 0, 0);
      rank_w(2, 3, 0, 0);
      for (int s = 0; s < 2; s++) begin
         sw_start = 1'b1; tick(); sw_start = 1'b0;
         repeat (19) tick();
         chk("R11 one rank per start", int'(conv_busy) + int'(grp_done), 0);
      end
      sw_start = 1'b1;
      wait_grp(3000, c);
      chk("R11 last rank ends group", c, 18);
      rd_chk("R11 rank0", 0, exp_res(1, 0));
      rd_chk("R11 rank1", 1, exp_res(2, 0));
      rd_chk("R11 rank2", 2, exp_res(3, 0));

      // R9: auto-chaining
      adc_en = 1'b0;
      cfg_w(1'b1, 0, 1, 1'b1, 1'b0);
      chk("R9 auto with edge rejected", int'(cfg_err), 1);
      cfg_w(1'b1, 0, 0, 1'b1, 1'b0);
      chk("R9 auto accepted", int'(cfg_err), 0);
      adc_en = 1'b1;
      rank_w(0, 5, 0, 0);
      sw_start = 1'b1; tick(); sw_start = 1'b0; tick();
      chk("R9 sw start ignored in auto", int'(sw_pend) + int'(conv_busy), 0);
      reg_done = 1'b1;
      wait_grp(3000, c);
      chk("R9 chained start", c, 17);
      rd_chk("R9 result", 0, exp_res(5, 0));

      // R12: stop rules
      reg_done = 1'b1; tick(); reg_done = 1'b0;
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      chk("R12 stop rejected in auto", int'(cfg_err), 1);
      chk("R12 keeps running", int'(conv_busy), 1);
      wait_grp(3000, c);
      chk("R12 group completes", int'(grp_done), 1);
      rd_chk("R12 result", 0, exp_res(5, 0));
      adc_en = 1'b0;
      cfg_w(1'b1, 0, 0, 1'b0, 1'b0);
      adc_en = 1'b1;
      rank_w(0, 5, 7, 0);
      sw_start = 1'b1; tick(); sw_start = 1'b0; tick(); tick();
      chk("R12 running", int'(conv_busy), 1);
      reg_pending = 1'b1; stop_req = 1'b1; tick(); stop_req = 1'b0; reg_pending = 1'b0;
      chk("R12 stop rejected with pending", int'(cfg_err), 1);
      chk("R12 still running", int'(conv_busy), 1);
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      chk("R12 stop accepted", int'(conv_busy), 0);
      chk("R12 no error", int'(cfg_err), 0);
      repeat (450) tick();
      chk("R12 no group end after stop", int'(grp_done), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule